// File: doc/BRIEF.md
# Sticky Priority Error Code Register

This block gathers per-frame error strobes from a digital audio receiver and keeps, as a 3-bit code, the most serious error seen since it was last cleared. Each strobe is a single-cycle pulse, synchronous to the master clock. When several strobes arrive together, the block takes the highest-ranked one. A later, less serious error never replaces a more serious one that is already held.

A select input drives the reporting and clearing. The block samples select through a short synchronizer on the master clock. While the sampled select is low, the code is reported as valid. Raising select for more than a set number of master clock cycles (eight by default) clears the held code. A shorter pulse leaves the code as it was. Software or a host pin controller reads the code while select is low and clears it with one long select pulse.

Top module: `err_code_latch`

## Requirements
- R1: After reset, `code_o` is 0 and `code_valid_o` is 1.
- R2: The event codes are: validity = 1, confidence = 2, slipped sample = 3, CRC = 4, parity = 5, biphase = 6, no lock = 7, and 0 means no error. When strobes coincide, the highest code is taken.
- R3: The held code never drops without a clear. A strobe whose code is lower than or equal to the held code leaves `code_o` unchanged, and so does a cycle with no strobe.
- R4: With the default `CRC_NEEDS_PRO` = 1, the CRC strobe is counted only while `pro_mode_i` is 1. Otherwise it is ignored.
- R5: Select held high for more than `CLR_MIN_CYCLES` (8) consecutive sampled cycles sets `code_o` to 0, provided no strobe arrives in the clearing cycle.
- R6: A select-high pulse of `CLR_MIN_CYCLES` cycles or fewer leaves `code_o` unchanged.
- R7: The select-high duration count restarts whenever sampled select goes low. Two 5-cycle high pulses split by one low cycle do not clear.
- R8: A strobe in the same cycle as the clear stays held: `code_o` becomes that strobe's code. A strobe one cycle before the clear is erased.
- R9: Only one clear happens per select-high period. Strobes that arrive while select stays high after the clear are held.
- R10: `code_valid_o` is 1 exactly when the sampled select is low. It follows `sel_i` after `SYNC_STAGES` (2) cycles.
- R11: A strobe present before a rising clock edge shows on `code_o` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Select line: low reports the code, a long high pulse clears it |
| evt_validity_i | input | 1 | Validity-bit-high strobe (code 1) |
| evt_conf_i | input | 1 | Confidence flag strobe (code 2) |
| evt_slip_i | input | 1 | Slipped sample strobe (code 3) |
| evt_crc_i | input | 1 | Channel status CRC error strobe (code 4) |
| evt_parity_i | input | 1 | Parity error strobe (code 5) |
| evt_biphase_i | input | 1 | Biphase coding violation strobe (code 6) |
| evt_nolock_i | input | 1 | Receiver out-of-lock strobe (code 7) |
| pro_mode_i | input | 1 | High when the stream carries professional-format channel status |
| code_o | output | 3 | Highest error code held since the last clear |
| code_valid_o | output | 1 | High while the sampled select is low |

## Verification
The bench aims at the clear-duration boundary: a pulse of exactly eight cycles must keep the code and one of nine must erase it. An off-by-one counter fails one of these two. A pulse broken by a single low cycle would clear by mistake if the counter did not restart. The bench places a strobe exactly in the clearing cycle and another one cycle earlier. A design that gives the clear priority would lose the first, and one that delays the clear would keep the second. It also holds select high long after the clear and raises a strobe there, which catches a design that keeps clearing for as long as select stays high. It drives lower-ranked strobes over a held code, and a CRC strobe outside professional mode, to catch priority and gating errors.

// File: rtl/ecl_pkg.sv
package ecl_pkg;

   localparam int unsigned CODE_W = 3;
   localparam int unsigned N_EVT  = 7;

   typedef enum logic [CODE_W-1:0] {
      ERR_NONE    = 3'd0,
      ERR_VALID   = 3'd1,
      ERR_CONF    = 3'd2,
      ERR_SLIP    = 3'd3,
      ERR_CRC     = 3'd4,
      ERR_PARITY  = 3'd5,
      ERR_BIPHASE = 3'd6,
      ERR_NOLOCK  = 3'd7
   } err_code_e;

   // bit i of the vector carries the strobe whose code is i
   typedef logic [N_EVT:1] evt_vec_t;

endpackage

// File: rtl/ecl_sel_qual.sv
module ecl_sel_qual #(
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned CLR_MIN_CYCLES = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sel_i,
   output logic sel_s_o,
   output logic clr_o
);

   localparam int unsigned CNT_MAX = CLR_MIN_CYCLES + 1;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CNT_W-1:0]       hi_cnt_q;

   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sync_q <= '0;
            else         sync_q <= sel_i;
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sync_q <= '0;
            else         sync_q <= {sync_q[SYNC_STAGES-2:0], sel_i};
         end
      end
   endgenerate

   assign sel_s_o = sync_q[SYNC_STAGES-1];

   // counts sampled-high cycles before the current one, saturating past the limit
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hi_cnt_q <= '0;
      end else if (!sel_s_o) begin
         hi_cnt_q <= '0;
      end else if (hi_cnt_q != CNT_W'(CNT_MAX)) begin
         hi_cnt_q <= hi_cnt_q + 1'b1;
      end
   end

   assign clr_o = sel_s_o && (hi_cnt_q == CNT_W'(CLR_MIN_CYCLES));

endmodule

// File: rtl/ecl_prio_enc.sv
module ecl_prio_enc
   import ecl_pkg::*;
#(
   parameter bit CRC_NEEDS_PRO = 1'b1
) (
   input  evt_vec_t           evt_i,
   input  logic               pro_i,
   output logic [CODE_W-1:0]  code_o
);

   evt_vec_t qual;

   generate
      for (genvar gi = 1; gi <= N_EVT; gi++) begin : g_qual
         if (CRC_NEEDS_PRO && (gi == int'(ERR_CRC))) begin : g_gated
            assign qual[gi] = evt_i[gi] & pro_i;
         end else begin : g_plain
            assign qual[gi] = evt_i[gi];
         end
      end
   endgenerate

   always_comb begin
      code_o = '0;
      for (int i = 1; i <= int'(N_EVT); i++) begin
         if (qual[i]) code_o = CODE_W'(i);
      end
   end

endmodule

// File: rtl/ecl_sticky.sv
module ecl_sticky
   import ecl_pkg::*;
(
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               clr_i,
   input  logic [CODE_W-1:0]  new_i,
   output logic [CODE_W-1:0]  code_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         code_o <= '0;
      end else if (clr_i) begin
         code_o <= new_i;
      end else if (new_i > code_o) begin
         code_o <= new_i;
      end
   end

endmodule

// File: rtl/err_code_latch.sv
module err_code_latch
   import ecl_pkg::*;
#(
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned CLR_MIN_CYCLES = 8,
   parameter bit          CRC_NEEDS_PRO  = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       sel_i,
   input  logic       evt_validity_i,
   input  logic       evt_conf_i,
   input  logic       evt_slip_i,
   input  logic       evt_crc_i,
   input  logic       evt_parity_i,
   input  logic       evt_biphase_i,
   input  logic       evt_nolock_i,
   input  logic       pro_mode_i,
   output logic [2:0] code_o,
   output logic       code_valid_o
);

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("err_code_latch: SYNC_STAGES must be at least 1");
      end
      if (CLR_MIN_CYCLES < 1) begin : g_bad_clr
         $error("err_code_latch: CLR_MIN_CYCLES must be at least 1");
      end
   endgenerate

   evt_vec_t            evt;
   logic                sel_s;
   logic                clr;
   logic [CODE_W-1:0]   new_code;
   logic [CODE_W-1:0]   code_q;

   assign evt = {evt_nolock_i, evt_biphase_i, evt_parity_i, evt_crc_i,
                 evt_slip_i, evt_conf_i, evt_validity_i};

   ecl_sel_qual #(
      .SYNC_STAGES    (SYNC_STAGES),
      .CLR_MIN_CYCLES (CLR_MIN_CYCLES)
   ) i_sel_qual (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (sel_i),
      .sel_s_o (sel_s),
      .clr_o   (clr)
   );

   ecl_prio_enc #(
      .CRC_NEEDS_PRO (CRC_NEEDS_PRO)
   ) i_prio_enc (
      .evt_i  (evt),
      .pro_i  (pro_mode_i),
      .code_o (new_code)
   );

   ecl_sticky i_sticky (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .new_i  (new_code),
      .code_o (code_q)
   );

   assign code_o       = code_q;
   assign code_valid_o = ~sel_s;

endmodule

// File: rtl/ecl_checker.sv
module ecl_checker #(
   parameter int unsigned CLR_MIN_CYCLES = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       sel_s,
   input logic       clr,
   input logic [2:0] new_code,
   input logic [2:0] code,
   input logic       pro_mode
);

   localparam int unsigned HC_W = $clog2(CLR_MIN_CYCLES + 2);

   logic [HC_W-1:0] hc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                hc_q <= '0;
      else if (!sel_s)                           hc_q <= '0;
      else if (hc_q != HC_W'(CLR_MIN_CYCLES + 1)) hc_q <= hc_q + 1'b1;
   end

   AST_NO_DROP_WITHOUT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (code >= $past(code)));                                  // R3

   AST_TAKES_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && (new_code > code)) |=> (code == $past(new_code)));       // R2

   AST_CLR_LOADS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (code == $past(new_code)));                               // R8

   AST_CLR_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      clr |-> (sel_s && (hc_q == HC_W'(CLR_MIN_CYCLES))));              // R6

   AST_SINGLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !clr);                                                    // R9

   AST_CRC_NEEDS_PRO: assert property (@(posedge clk) disable iff (!rst_n)
      (new_code == 3'd4) |-> pro_mode);                                 // R4

endmodule

bind err_code_latch ecl_checker #(
   .CLR_MIN_CYCLES (CLR_MIN_CYCLES)
) i_ecl_checker (
   .clk      (clk_i),
   .rst_n    (rst_ni),
   .sel_s    (sel_s),
   .clr      (clr),
   .new_code (new_code),
   .code     (code_q),
   .pro_mode (pro_mode_i)
);

// File: tb/test_err_code_latch.sv
module test_err_code_latch;

   localparam int SYNC = 2;
   localparam int NCLR = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 1'b0;
   logic [6:0] ev = '0;
   logic       pro = 1'b0;
   logic [2:0] code;
   logic       code_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   err_code_latch #(
      .SYNC_STAGES    (SYNC),
      .CLR_MIN_CYCLES (NCLR),
      .CRC_NEEDS_PRO  (1'b1)
   ) i_err_code_latch (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .sel_i          (sel),
      .evt_validity_i (ev[0]),
      .evt_conf_i     (ev[1]),
      .evt_slip_i     (ev[2]),
      .evt_crc_i      (ev[3]),
      .evt_parity_i   (ev[4]),
      .evt_biphase_i  (ev[5]),
      .evt_nolock_i   (ev[6]),
      .pro_mode_i     (pro),
      .code_o         (code),
      .code_valid_o   (code_valid)
   );

   // {clear first, pro, strobes nolock..validity, expected code}
   localparam logic [11:0] VEC [12] = '{
      {1'b1, 1'b0, 7'b0000001, 3'd1},
      {1'b0, 1'b0, 7'b0000010, 3'd2},
      {1'b0, 1'b0, 7'b0000001, 3'd2},
      {1'b0, 1'b0, 7'b0001000, 3'd2},
      {1'b0, 1'b1, 7'b0001000, 3'd4},
      {1'b0, 1'b0, 7'b0000100, 3'd4},
      {1'b1, 1'b0, 7'b0010001, 3'd5},
      {1'b1, 1'b1, 7'b1111111, 3'd7},
      {1'b1, 1'b0, 7'b0001100, 3'd3},
      {1'b1, 1'b0, 7'b0100000, 3'd6},
      {1'b0, 1'b0, 7'b1000000, 3'd7},
      {1'b1, 1'b0, 7'b0000000, 3'd0}
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic pulse(input logic [6:0] e, input logic p);
      ev  = e;
      pro = p;
      @(negedge clk);
      ev  = '0;
      pro = 1'b0;
   endtask

   task automatic hold_sel(input int n);
      sel = 1'b1;
      repeat (n) @(negedge clk);
      sel = 1'b0;
      repeat (SYNC + 2) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset code", code, 0);
      check("R1 reset valid", code_valid, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R2 R3 R4 R5 R11
      for (int i = 0; i < 12; i++) begin
         if (VEC[i][11]) hold_sel(NCLR + 1);
         pulse(VEC[i][9:3], VEC[i][10]);
         check($sformatf("R2/R3/R4/R11 vector %0d", i), code, int'(VEC[i][2:0]));
      end

      // R3: idle cycles keep the code
      pulse(7'b0100000, 1'b0);
      repeat (5) @(negedge clk);
      check("R3 hold without strobes", code, 6);

      // R6: exactly eight cycles high does not clear
      hold_sel(NCLR);
      check("R6 eight-cycle pulse keeps code", code, 6);

      // R5: nine cycles clear
      hold_sel(NCLR + 1);
      check("R5 nine-cycle pulse clears", code, 0);

      // R7: broken pulse does not clear
      pulse(7'b0100000, 1'b0);
      sel = 1'b1;
      repeat (5) @(negedge clk);
      sel = 1'b0;
      @(negedge clk);
      sel = 1'b1;
      repeat (5) @(negedge clk);
      sel = 1'b0;
      repeat (SYNC + 2) @(negedge clk);
      check("R7 counter restarts on low", code, 6);

      // R8: strobe in the clearing cycle stays held
      pulse(7'b1000000, 1'b0);
      sel = 1'b1;
      for (int k = 1; k <= SYNC + NCLR + 1; k++) begin
         @(negedge clk);
         if (k == SYNC + NCLR) ev = 7'b0010000;
         else                  ev = '0;
      end
      sel = 1'b0;
      repeat (SYNC + 2) @(negedge clk);
      check("R8 strobe with clear kept", code, 5);

      // R8: strobe one cycle before the clear is erased
      sel = 1'b1;
      for (int k = 1; k <= SYNC + NCLR + 1; k++) begin
         @(negedge clk);
         if (k == SYNC + NCLR - 1) ev = 7'b0100000;
         else                      ev = '0;
      end
      sel = 1'b0;
      repeat (SYNC + 2) @(negedge clk);
      check("R8 strobe before clear erased", code, 0);

      // R9 and R10: long hold, strobe after the clear is kept
      pulse(7'b0010000, 1'b0);
      sel = 1'b1;
      for (int k = 1; k <= 20; k++) begin
         @(negedge clk);
         if (k == 5) check("R10 valid low while select high", code_valid, 0);
         if (k == 15) ev = 7'b0000100;
         else         ev = '0;
      end
      sel = 1'b0;
      repeat (SYNC - 1) @(negedge clk);
      check("R10 valid still low within sync delay", code_valid, 0);
      @(negedge clk);
      check("R10 valid back high", code_valid, 1);
      repeat (2) @(negedge clk);
      check("R9 strobe after clear kept", code, 3);

      finish_run();
   end

endmodule